// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Host-Supplied Parity and Infrared Pulse Shaping

This block turns one data word at a time into an asynchronous serial frame on a single output line. A host writes a word through a one-entry holding buffer. When the shifter is free the word moves across, and the frame goes out as follows: a low start bit, then the data bits starting with the least significant, then an optional parity bit, then a high stop bit. The data field is either 7 or 8 bits wide. The parity bit is never computed: the bit the host writes alongside the data is sent as it is.

Bit timing comes from an external oversampling strobe, `baudTick`, that pulses 16 times per bit period. The output line has two shapes. The plain line idles high and carries each bit's level for the whole bit. The infrared-style line idles low and marks every zero bit with a short high pulse at the start of the bit. The buffer-empty flag rises as soon as the held word enters the shifter, so the host can queue the next word while the current frame is still going out. A low level on the halt input abandons any frame at once and empties the block.

Top module: `uart_tx`

## Requirements
- R1: After reset, `bufEmpty` is 1 and `txOut` rests at the idle level. The idle level is 1 when `cfgIrda`=0 and 0 when `cfgIrda`=1.
- R2: A frame sent with `cfgIrda`=0 is a 0 start bit, then the data bits least significant first, then a 1 stop bit. Every bit lasts 16 `baudTick` pulses.
- R3: With `cfgWord8`=1 the data field is `wrData[7:0]` (8 bits). With `cfgWord8`=0 it is `wrData[6:0]` (7 bits), and `wrData[7]` has no effect on the line.
- R4: With `cfgParityEn`=1, one extra bit equal to `wrParity` follows the last data bit, whatever the data's actual parity. With `cfgParityEn`=0 the stop bit follows the data directly.
- R5: `bufEmpty` falls in the cycle after an accepted write. It rises in the same cycle in which the frame's start bit appears. A word written during a frame is sent straight after that frame's stop bit.
- R6: A write while `bufEmpty`=0 is dropped. The held word is unchanged and no extra frame is sent.
- R7: With `cfgIrda`=1, each 0 bit (including the start bit) is a high pulse 3 `baudTick` periods wide at the start of the bit. Each 1 bit, and the idle line, stays low.
- R8: While `haltN`=0, any frame in progress is dropped. From the next cycle the line is at the idle level and `bufEmpty`=1, writes are ignored, and nothing is sent after `haltN` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| haltN | input | 1 | Halt, active low: abandons the frame and empties the buffer |
| baudTick | input | 1 | One-cycle strobe at 16 times the bit rate |
| cfgWord8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgParityEn | input | 1 | 1: append the host parity bit |
| cfgIrda | input | 1 | 1: infrared-style pulse output, 0: plain level output |
| wrValid | input | 1 | Write strobe for the holding buffer |
| wrData | input | DATA_W | Data word, least significant bit sent first |
| wrParity | input | 1 | Parity bit to send as written |
| bufEmpty | output | 1 | Holding buffer can accept a word |
| txOut | output | 1 | Serial output line |

## Verification
Each scenario traces a whole frame at the port and compares it bit by bit with an expected frame. A wrong bit count, a lost parity bit or a data bit in the wrong order therefore shows as a wrong level at the middle of some bit, within one bit period of the fault. In pulse mode a wrong tick counter shows as a pulse width other than 12 clocks during the first zero data bit. A buffer-flag fault shows within one cycle of a write or a frame start. A missing or extra frame shows during the idle window checked after each frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;      // move held word into the shifter
    logic shift;     // advance to the next frame bit
    logic active;    // a frame is on the line
    logic pulseWin;  // inside the short-pulse window of the current bit
  } txStrobe_t;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      haltN,
  input  logic      baudTick,
  input  logic      bufFull,
  input  logic      cfgWord8,
  input  logic      cfgParityEn,
  output txStrobe_t strobe
);
  localparam int SHORT_W = DATA_W - 1;
  localparam int FRAME_W = DATA_W + 3;
  localparam int TICK_W  = $clog2(OVS);
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  typedef enum logic {S_IDLE, S_RUN} ctrlState_t;

  ctrlState_t        state;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BIT_W-1:0]  lastBit;
  logic [BIT_W-1:0]  lastBitNext;
  logic              startFrame;
  logic              bitEnd;

  // index of the stop bit: data bits + optional parity + start bit
  assign lastBitNext = BIT_W'(SHORT_W + 1) + BIT_W'(cfgWord8) + BIT_W'(cfgParityEn);
  assign startFrame  = (state == S_IDLE) && bufFull && haltN;
  assign bitEnd      = baudTick && (tickCnt == TICK_W'(OVS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      lastBit <= '0;
    end else if (!haltN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (startFrame) begin
            state   <= S_RUN;
            tickCnt <= '0;
            bitCnt  <= '0;
            lastBit <= lastBitNext;
          end
        end
        default: begin
          if (baudTick) begin
            if (bitEnd) begin
              tickCnt <= '0;
              if (bitCnt == lastBit) state <= S_IDLE;
              else                   bitCnt <= bitCnt + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.load     = startFrame;
    strobe.shift    = (state == S_RUN) && bitEnd && (bitCnt != lastBit);
    strobe.active   = (state == S_RUN);
    strobe.pulseWin = (tickCnt < TICK_W'(PULSE_TICKS));
  end
endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrParity,
  input  logic              cfgWord8,
  input  logic              cfgParityEn,
  input  logic              cfgIrda,
  input  txStrobe_t         strobe,
  output logic              bufFull,
  output logic              txOut
);
  localparam int SHORT_W = DATA_W - 1;
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [DATA_W-1:0]  bufData;
  logic               bufPar;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frameVec;
  logic [IDX_W-1:0]   parIdx;
  logic               curBit;
  logic               lineNrz;
  logic               lineIr;

  // Frame image, bit 0 first on the line; unused upper positions stay 1
  assign parIdx = IDX_W'(SHORT_W + 1) + IDX_W'(cfgWord8);

  always_comb begin
    frameVec    = '1;
    frameVec[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < SHORT_W || cfgWord8) frameVec[i+1] = bufData[i];
    end
    if (cfgParityEn) frameVec[parIdx] = bufPar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull  <= 1'b0;
      bufData  <= '0;
      bufPar   <= 1'b0;
      shiftReg <= '1;
    end else if (!haltN) begin
      bufFull  <= 1'b0;
      shiftReg <= '1;
    end else begin
      if (wrValid && !bufFull) begin
        bufFull <= 1'b1;
        bufData <= wrData;
        bufPar  <= wrParity;
      end else if (strobe.load) begin
        bufFull <= 1'b0;
      end
      if (strobe.load)       shiftReg <= frameVec;
      else if (strobe.shift) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign curBit  = shiftReg[0];
  assign lineNrz = strobe.active ? curBit : 1'b1;
  assign lineIr  = strobe.active && !curBit && strobe.pulseWin;
  assign txOut   = cfgIrda ? lineIr : lineNrz;
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltN,
  input  logic              baudTick,
  input  logic              cfgWord8,
  input  logic              cfgParityEn,
  input  logic              cfgIrda,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrParity,
  output logic              bufEmpty,
  output logic              txOut
);
  txStrobe_t txStrobe;
  logic      bufFull;

  uart_tx_ctrl #(.DATA_W(DATA_W), .OVS(OVS), .PULSE_TICKS(PULSE_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .haltN(haltN), .baudTick(baudTick),
    .bufFull(bufFull), .cfgWord8(cfgWord8), .cfgParityEn(cfgParityEn),
    .strobe(txStrobe)
  );

  uart_tx_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .haltN(haltN), .wrValid(wrValid),
    .wrData(wrData), .wrParity(wrParity), .cfgWord8(cfgWord8),
    .cfgParityEn(cfgParityEn), .cfgIrda(cfgIrda), .strobe(txStrobe),
    .bufFull(bufFull), .txOut(txOut)
  );

  assign bufEmpty = !bufFull;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk #(
  parameter int PULSE = 3
) (
  input logic clk,
  input logic rstN,
  input logic haltN,
  input logic baudTick,
  input logic cfgIrda,
  input logic wrValid,
  input logic bufEmpty,
  input logic txOut,
  input logic busy
);
  logic [7:0] hiTicks;

  // ticks seen while the pulse-mode line is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  hiTicks <= '0;
    else if (!(cfgIrda && txOut)) hiTicks <= '0;
    else if (baudTick && hiTicks != 8'hFF) hiTicks <= hiTicks + 1'b1;
  end

  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (txOut == !cfgIrda));

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !cfgIrda) |-> !txOut);

  a_r5_fall_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufEmpty) |-> $past(wrValid));

  a_r5_empty_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> bufEmpty);

  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    cfgIrda |-> (hiTicks <= 8'(PULSE)));

  a_r8_halt_clears: assert property (@(posedge clk) disable iff (!rstN)
    !haltN |=> (bufEmpty && !busy));
endmodule

bind uart_tx uart_tx_chk #(.PULSE(PULSE_TICKS)) chk_i (
  .clk(clk), .rstN(rstN), .haltN(haltN), .baudTick(baudTick),
  .cfgIrda(cfgIrda), .wrValid(wrValid), .bufEmpty(bufEmpty),
  .txOut(txOut), .busy(txStrobe.active)
);

// File: tb/uart_tx_tb_top.sv
module uart_tx_tb_top;
  localparam int CLK_P   = 10;
  localparam int TICK_DV = 4;            // clocks per baud tick
  localparam int BIT_CLK = 16 * TICK_DV; // clocks per bit

  logic       clk = 0;
  logic       rstN = 0;
  logic       haltN = 1;
  logic       baudTick = 0;
  logic       cfgWord8 = 1;
  logic       cfgParityEn = 0;
  logic       cfgIrda = 0;
  logic       wrValid = 0;
  logic [7:0] wrData = '0;
  logic       wrParity = 0;
  logic       bufEmpty;
  logic       txOut;

  int nChecks = 0;
  int nFail   = 0;
  int tickDiv = 0;

  uart_tx dut_i (
    .clk(clk), .rstN(rstN), .haltN(haltN), .baudTick(baudTick),
    .cfgWord8(cfgWord8), .cfgParityEn(cfgParityEn), .cfgIrda(cfgIrda),
    .wrValid(wrValid), .wrData(wrData), .wrParity(wrParity),
    .bufEmpty(bufEmpty), .txOut(txOut)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    tickDiv  <= (tickDiv == TICK_DV - 1) ? 0 : tickDiv + 1;
    baudTick <= (tickDiv == TICK_DV - 1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic buildFrame(input logic [7:0] d, input logic p,
                            output logic [15:0] bits, output int n);
    bits = '1; n = 0;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < (cfgWord8 ? 8 : 7); i++) begin bits[n] = d[i]; n++; end
    if (cfgParityEn) begin bits[n] = p; n++; end
    bits[n] = 1'b1; n++;
  endtask

  task automatic writeWord(input logic [7:0] d, input logic p);
    @(negedge clk);
    wrValid = 1; wrData = d; wrParity = p;
    @(negedge clk);
    wrValid = 0;
  endtask

  task automatic waitLevel(input logic lvl, input string req, output bit ok);
    ok = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (txOut == lvl) begin ok = 1; break; end
    end
    check(ok, req, !lvl, lvl);
  endtask

  // plain line: sample the middle of each bit and one bit after the stop
  task automatic captureNrz(input logic [7:0] d, input logic p, input string req);
    logic [15:0] bits; int n; bit ok;
    buildFrame(d, p, bits, n);
    waitLevel(1'b0, {req, " start edge"}, ok);
    if (!ok) return;
    for (int k = 0; k <= n; k++) begin
      repeat (k == 0 ? BIT_CLK/2 : BIT_CLK) @(negedge clk);
      check(txOut == (k < n ? bits[k] : 1'b1), req, txOut, (k < n ? bits[k] : 1'b1));
    end
  endtask

  task automatic t_reset();
    check(bufEmpty == 1'b1, "R1 reset bufEmpty", bufEmpty, 1);
    check(txOut == 1'b1, "R1 idle high plain", txOut, 1);
    @(negedge clk); cfgIrda = 1;
    #1 check(txOut == 1'b0, "R1 idle low pulse mode", txOut, 0);
    @(negedge clk); cfgIrda = 0;
  endtask

  task automatic t_frame8();
    cfgWord8 = 1; cfgParityEn = 0;
    writeWord(8'hA5, 0); captureNrz(8'hA5, 0, "R2 frame A5");
    writeWord(8'h3C, 0); captureNrz(8'h3C, 0, "R2 frame 3C");
  endtask

  task automatic t_word7();
    cfgWord8 = 0; cfgParityEn = 1;
    writeWord(8'h80, 1); captureNrz(8'h80, 1, "R3 seven-bit ignores bit7");
    cfgWord8 = 1;
    writeWord(8'h80, 0); captureNrz(8'h80, 0, "R3 eight-bit sends bit7");
  endtask

  task automatic t_parity();
    cfgWord8 = 1; cfgParityEn = 1;
    writeWord(8'h00, 1); captureNrz(8'h00, 1, "R4 parity verbatim 1");
    writeWord(8'h01, 0); captureNrz(8'h01, 0, "R4 parity verbatim 0");
    cfgParityEn = 0;
  endtask

  task automatic t_buffer();
    bit ok;
    cfgWord8 = 1; cfgParityEn = 0;
    writeWord(8'hFF, 0);
    check(bufEmpty == 1'b0, "R5 full after write", bufEmpty, 0);
    ok = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (bufEmpty) begin ok = 1; break; end
    end
    check(ok, "R5 empty at frame start", bufEmpty, 1);
    check(txOut == 1'b0, "R5 start bit with empty", txOut, 0);
    writeWord(8'h5A, 0);
    check(bufEmpty == 1'b0, "R5 queued during frame", bufEmpty, 0);
    writeWord(8'h00, 0);                 // dropped: buffer full
    repeat (BIT_CLK + 20) @(negedge clk); // past the start bit of FF
    captureNrz(8'h5A, 0, "R6 queued word kept");
    ok = 1;
    for (int c = 0; c < 12 * BIT_CLK; c++) begin
      @(negedge clk);
      if (!txOut) ok = 0;
    end
    check(ok, "R6 no extra frame", ok, 1);
    check(bufEmpty == 1'b1, "R6 buffer empty at end", bufEmpty, 1);
  endtask

  task automatic t_irda();
    logic [15:0] bits; int n; bit ok; int cnt [16];
    cfgIrda = 1; cfgWord8 = 1; cfgParityEn = 0;
    buildFrame(8'h96, 0, bits, n);
    foreach (cnt[i]) cnt[i] = 0;
    writeWord(8'h96, 0);
    waitLevel(1'b1, "R7 start pulse", ok);
    if (ok) begin
      for (int c = 0; c < n * BIT_CLK + 40; c++) begin
        if (c > 0) @(negedge clk);
        if (((c + 8) % BIT_CLK) < 48) cnt[(c + 8) / BIT_CLK] += int'(txOut);
      end
      check(cnt[0] >= 9 && cnt[0] <= 12, "R7 start pulse width", cnt[0], 12);
      for (int k = 1; k <= n; k++) begin
        int exp = (k < n && !bits[k]) ? 3 * TICK_DV : 0;
        check(cnt[k] == exp, "R7 bit pulse", cnt[k], exp);
      end
    end
    check(txOut == 1'b0, "R7 idle low", txOut, 0);
    cfgIrda = 0;
    @(negedge clk);
  endtask

  task automatic t_halt();
    bit ok;
    cfgWord8 = 1; cfgParityEn = 0;
    writeWord(8'h00, 0);
    waitLevel(1'b0, "R8 frame begins", ok);
    repeat (100) @(negedge clk);
    haltN = 0;
    @(negedge clk);
    check(txOut == 1'b1, "R8 line idle on halt", txOut, 1);
    check(bufEmpty == 1'b1, "R8 empty on halt", bufEmpty, 1);
    writeWord(8'h00, 0);
    check(bufEmpty == 1'b1, "R8 write ignored in halt", bufEmpty, 1);
    haltN = 1;
    ok = 1;
    for (int c = 0; c < 12 * BIT_CLK; c++) begin
      @(negedge clk);
      if (!txOut) ok = 0;
    end
    check(ok, "R8 nothing resumes", ok, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_frame8();
    t_word7();
    t_parity();
    t_buffer();
    t_irda();
    t_halt();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule